// File: doc/BRIEF.md
# Completion Timestamp Capture Formatter

This block takes a snapshot of time when a packet-completion event strikes and encodes it into a 38-bit stamp. It also produces a two-bit code that names the format used. The stamp leaves the block as two pieces: a 22-bit upper part and a 16-bit lower part. A consumer rebuilds the whole value as upper shifted left by 16, ORed with lower. The completion writer can place the two pieces in separate fields of a completion record.

Three time sources feed the block: a free-running nanosecond counter, a wall clock given as seconds plus nanoseconds, and the original time of a mirrored packet. A configuration selector chooses the format for ordinary trapped packets, but only while its enable bit is high. Mirrored packets always use the fourth format, which carries the original packet's time. The captured stamp and its code stay frozen, with a valid flag, until the next event.

The control is a two-state machine. `ST_EMPTY` holds from reset until the first event, and `ST_HELD` holds a stamp. The transitions are `EMPTY_TO_HELD` on the first strobe and `HELD_RECAPTURE`, a self-loop on each later strobe. Reset returns the machine to `ST_EMPTY`.

Top module: `cmpl_stamp_fmt`

## Requirements
- R1: While reset is asserted and after it is released with no event, `stamp_valid` is 0 and `stamp_type`, `stamp_hi` and `stamp_lo` are all 0.
- R2: The outputs take the value formed from the inputs present at a clock edge where `evt` is high, so they change one edge after the strobe, and `stamp_valid` becomes 1.
- R3: With `evt` low, the outputs hold their values no matter how the time inputs, the flags or the configuration change.
- R4: Type code 0 (coarse ticks) gives `stamp_hi` = 0 and `stamp_lo` = `frc_ns[25:10]`, one tick per 1024 ns. This code is chosen for a non-mirrored event whenever `cfg_fmt_en` is 0, whatever the value of `cfg_fmt`.
- R5: With `cfg_fmt_en` = 1 and `cfg_fmt` = 1, a non-mirrored event gives type code 1 and the low 38 bits of `frc_ns`, with `stamp_hi` = `frc_ns[37:16]` and `stamp_lo` = `frc_ns[15:0]`.
- R6: With `cfg_fmt_en` = 1 and `cfg_fmt` = 2, a non-mirrored event gives type code 2. The 38-bit stamp is `utc_sec[7:0]` in bits 37:30 and `utc_ns` in bits 29:0.
- R7: An event with `evt_mirror` = 1 always gives type code 3, whatever the configuration. The stamp is `orig_sec[7:0]` in bits 37:30 and `orig_ns` in bits 29:0.
- R8: A non-mirrored event never gives type code 3. With `cfg_fmt_en` = 1 and `cfg_fmt` = 3 it falls back to type code 0.
- R9: The coarse tick count wraps at 16 bits: bits of `frc_ns` above bit 25 have no effect on a type-0 stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt_en | input | 1 | Enables the format selector for non-mirrored events |
| cfg_fmt | input | 2 | Format selector: 0 ticks, 1 free-running, 2 seconds+ns |
| frc_ns | input | 64 | Free-running nanosecond counter |
| utc_sec | input | 32 | Wall-clock seconds |
| utc_ns | input | 30 | Wall-clock nanoseconds |
| evt | input | 1 | Completion event strobe, one cycle per capture |
| evt_mirror | input | 1 | Event belongs to a mirrored packet |
| orig_sec | input | 32 | Original packet seconds (mirrored traffic) |
| orig_ns | input | 30 | Original packet nanoseconds (mirrored traffic) |
| stamp_valid | output | 1 | A stamp has been captured since reset |
| stamp_type | output | 2 | Format code of the held stamp |
| stamp_hi | output | 22 | Stamp bits 37:16 |
| stamp_lo | output | 16 | Stamp bits 15:0 |

## Verification
The assertions treat `evt_mirror` and the configuration as meaningful only on strobe cycles. They also assume the time inputs are stable around the sampling edge and carry no unknown values. The stimulus drives every input on the falling clock edge and keeps `evt` high for a single cycle per capture. Between strobes it changes the time inputs and flags freely, which exercises the hold property without ever violating these assumptions.

// File: rtl/cmpl_stamp_pkg.sv
package cmpl_stamp_pkg;

    typedef enum logic [1:0] {
        TS_TICK   = 2'd0,
        TS_FREE   = 2'd1,
        TS_WALL   = 2'd2,
        TS_MIRROR = 2'd3
    } ts_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/cmpl_stamp_kind_sel.sv
module cmpl_stamp_kind_sel
    import cmpl_stamp_pkg::*;
(
    input  logic       cfg_en,
    input  logic [1:0] cfg_sel,
    input  logic       mirror,
    output ts_kind_e   kind
);

    always_comb begin
        if (mirror) begin
            kind = TS_MIRROR;
        end else if (!cfg_en) begin
            kind = TS_TICK;
        end else begin
            unique case (cfg_sel)
                2'd1:    kind = TS_FREE;
                2'd2:    kind = TS_WALL;
                default: kind = TS_TICK;
            endcase
        end
    end

endmodule

// File: rtl/cmpl_stamp_encode.sv
module cmpl_stamp_encode
    import cmpl_stamp_pkg::*;
#(
    parameter int FRC_W      = 64,
    parameter int SEC_W      = 32,
    parameter int NSEC_W     = 30,
    parameter int TS_W       = 38,
    parameter int TICK_SHIFT = 10,
    parameter int TICK_W     = 16
) (
    input  ts_kind_e          kind,
    input  logic [FRC_W-1:0]  frc,
    input  logic [SEC_W-1:0]  wall_sec,
    input  logic [NSEC_W-1:0] wall_ns,
    input  logic [SEC_W-1:0]  org_sec,
    input  logic [NSEC_W-1:0] org_ns,
    output logic [TS_W-1:0]   stamp
);

    localparam int SEC_KEEP = TS_W - NSEC_W;

    logic unused_hi_bits;
    assign unused_hi_bits = ^{frc[FRC_W-1:TS_W],
                              wall_sec[SEC_W-1:SEC_KEEP],
                              org_sec[SEC_W-1:SEC_KEEP]};

    always_comb begin
        unique case (kind)
            TS_TICK:   stamp = TS_W'(frc[TICK_SHIFT +: TICK_W]);
            TS_FREE:   stamp = frc[TS_W-1:0];
            TS_WALL:   stamp = {wall_sec[SEC_KEEP-1:0], wall_ns};
            TS_MIRROR: stamp = {org_sec[SEC_KEEP-1:0], org_ns};
            default:   stamp = '0;
        endcase
    end

endmodule

// File: rtl/cmpl_stamp_capture.sv
module cmpl_stamp_capture
    import cmpl_stamp_pkg::*;
#(
    parameter int TS_W = 38,
    parameter int LO_W = 16,
    parameter int HI_W = TS_W - LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    input  logic            mirror,
    input  ts_kind_e        kind_in,
    input  logic [TS_W-1:0] stamp_in,
    output logic            valid,
    output logic [1:0]      kind_out,
    output logic [HI_W-1:0] hi,
    output logic [LO_W-1:0] lo
);

    cap_state_e state_q, state_d;
    logic [TS_W-1:0] stamp_q;
    ts_kind_e        kind_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (evt) state_d = ST_HELD;   // EMPTY_TO_HELD
            ST_HELD:  state_d = ST_HELD;            // HELD_RECAPTURE
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            kind_q  <= TS_TICK;
        end else if (evt) begin
            stamp_q <= stamp_in;
            kind_q  <= kind_in;
        end
    end

    assign valid    = (state_q == ST_HELD);
    assign kind_out = kind_q;
    assign hi       = stamp_q[TS_W-1:LO_W];
    assign lo       = stamp_q[LO_W-1:0];

    AST_VALID_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> valid);                                              // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ($stable(hi) && $stable(lo) && $stable(kind_out) && $stable(valid))); // R3
    AST_TICK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind_out == 2'd0) |-> (hi == '0));                 // R4
    AST_MIRROR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mirror) |=> (kind_out == 2'd3));                     // R7
    AST_PLAIN_NOT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !mirror) |=> (kind_out != 2'd3));                    // R8
    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (hi == '0 && lo == '0 && kind_out == 2'd0));      // R1

endmodule

// File: rtl/cmpl_stamp_fmt.sv
module cmpl_stamp_fmt
    import cmpl_stamp_pkg::*;
#(
    parameter int FRC_W      = 64,
    parameter int SEC_W      = 32,
    parameter int NSEC_W     = 30,
    parameter int TS_W       = 38,
    parameter int LO_W       = 16,
    parameter int TICK_SHIFT = 10,
    parameter int HI_W       = TS_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fmt_en,
    input  logic [1:0]        cfg_fmt,
    input  logic [FRC_W-1:0]  frc_ns,
    input  logic [SEC_W-1:0]  utc_sec,
    input  logic [NSEC_W-1:0] utc_ns,
    input  logic              evt,
    input  logic              evt_mirror,
    input  logic [SEC_W-1:0]  orig_sec,
    input  logic [NSEC_W-1:0] orig_ns,
    output logic              stamp_valid,
    output logic [1:0]        stamp_type,
    output logic [HI_W-1:0]   stamp_hi,
    output logic [LO_W-1:0]   stamp_lo
);

    ts_kind_e        kind;
    logic [TS_W-1:0] stamp;

    cmpl_stamp_kind_sel u_sel (
        .cfg_en  (cfg_fmt_en),
        .cfg_sel (cfg_fmt),
        .mirror  (evt_mirror),
        .kind    (kind)
    );

    cmpl_stamp_encode #(
        .FRC_W      (FRC_W),
        .SEC_W      (SEC_W),
        .NSEC_W     (NSEC_W),
        .TS_W       (TS_W),
        .TICK_SHIFT (TICK_SHIFT),
        .TICK_W     (LO_W)
    ) u_enc (
        .kind     (kind),
        .frc      (frc_ns),
        .wall_sec (utc_sec),
        .wall_ns  (utc_ns),
        .org_sec  (orig_sec),
        .org_ns   (orig_ns),
        .stamp    (stamp)
    );

    cmpl_stamp_capture #(
        .TS_W (TS_W),
        .LO_W (LO_W),
        .HI_W (HI_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .mirror   (evt_mirror),
        .kind_in  (kind),
        .stamp_in (stamp),
        .valid    (stamp_valid),
        .kind_out (stamp_type),
        .hi       (stamp_hi),
        .lo       (stamp_lo)
    );

endmodule

// File: tb/cmpl_stamp_fmt_bench.sv
module cmpl_stamp_fmt_bench;

    typedef struct packed {
        logic        en;
        logic [1:0]  cfg;
        logic        mir;
        logic [63:0] frc;
        logic [31:0] sec;
        logic [29:0] ns;
        logic [31:0] osec;
        logic [29:0] ons;
        logic [1:0]  e_type;
        logic [21:0] e_hi;
        logic [15:0] e_lo;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R4: enable low, cfg 1 ignored, tick = frc[25:10]
        '{1'b0, 2'd1, 1'b0, 64'h0000_0000_00AB_CC00, 32'h0000_0011, 30'h0000_0022,
          32'h0000_0033, 30'h0000_0044, 2'd0, 22'h000000, 16'h2AF3},
        // R5: free-running, low 38 bits
        '{1'b1, 2'd1, 1'b0, 64'hFFFF_FFC1_2345_6789, 32'h0000_0055, 30'h0000_0066,
          32'h0000_0077, 30'h0000_0088, 2'd1, 22'h012345, 16'h6789},
        // R6: seconds+ns
        '{1'b1, 2'd2, 1'b0, 64'h0000_0000_FFFF_FFFF, 32'h0000_12A5, 30'h1234_5678,
          32'h0000_0099, 30'h0000_00AA, 2'd2, 22'h295234, 16'h5678},
        // R7: mirror overrides cfg 1
        '{1'b1, 2'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 32'h0000_00BB, 30'h0000_00CC,
          32'h0000_0003, 30'h3FFF_FFFF, 2'd3, 22'h00FFFF, 16'hFFFF},
        // R7: mirror with enable low
        '{1'b0, 2'd0, 1'b1, 64'h0000_0000_0000_0400, 32'h0000_00DD, 30'h0000_00EE,
          32'hABCD_00FF, 30'h0000_0000, 2'd3, 22'h3FC000, 16'h0000},
        // R8: cfg 3 non-mirror falls back to ticks
        '{1'b1, 2'd3, 1'b0, 64'h0000_0000_0000_0400, 32'h0000_0101, 30'h0000_0202,
          32'h0000_0303, 30'h0000_0404, 2'd0, 22'h000000, 16'h0001},
        // R9: tick wraps, bit 26 has no effect
        '{1'b1, 2'd0, 1'b0, 64'hFFFF_FFFF_07FF_FC00, 32'h0000_0505, 30'h0000_0606,
          32'h0000_0707, 30'h0000_0808, 2'd0, 22'h000000, 16'hFFFF},
        // R4: enable low, cfg 2 ignored
        '{1'b0, 2'd2, 1'b0, 64'h0000_0000_0000_0800, 32'h0000_0909, 30'h0000_0A0A,
          32'h0000_0B0B, 30'h0000_0C0C, 2'd0, 22'h000000, 16'h0002}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_fmt_en;
    logic [1:0]  cfg_fmt;
    logic [63:0] frc_ns;
    logic [31:0] utc_sec;
    logic [29:0] utc_ns;
    logic        evt;
    logic        evt_mirror;
    logic [31:0] orig_sec;
    logic [29:0] orig_ns;
    logic        stamp_valid;
    logic [1:0]  stamp_type;
    logic [21:0] stamp_hi;
    logic [15:0] stamp_lo;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cmpl_stamp_fmt u_cmpl_stamp_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_fmt_en  (cfg_fmt_en),
        .cfg_fmt     (cfg_fmt),
        .frc_ns      (frc_ns),
        .utc_sec     (utc_sec),
        .utc_ns      (utc_ns),
        .evt         (evt),
        .evt_mirror  (evt_mirror),
        .orig_sec    (orig_sec),
        .orig_ns     (orig_ns),
        .stamp_valid (stamp_valid),
        .stamp_type  (stamp_type),
        .stamp_hi    (stamp_hi),
        .stamp_lo    (stamp_lo)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic v, input logic [1:0] t,
                             input logic [21:0] h, input logic [15:0] l);
        check({req, " valid"}, 64'(stamp_valid), 64'(v));
        check({req, " type"},  64'(stamp_type),  64'(t));
        check({req, " hi"},    64'(stamp_hi),    64'(h));
        check({req, " lo"},    64'(stamp_lo),    64'(l));
    endtask

    task automatic drive(input vec_t v, input logic strobe);
        cfg_fmt_en = v.en;
        cfg_fmt    = v.cfg;
        evt_mirror = v.mir;
        frc_ns     = v.frc;
        utc_sec    = v.sec;
        utc_ns     = v.ns;
        orig_sec   = v.osec;
        orig_ns    = v.ons;
        evt        = strobe;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(VECS[1], 1'b1);
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 1'b0, 2'd0, 22'h0, 16'h0);
        evt   = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 after release", 1'b0, 2'd0, 22'h0, 16'h0);

        // Table walk: strobe for one edge, check one edge later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            check("R2 no change before edge", 64'(stamp_valid), 64'(i != 0));
            @(negedge clk);
            evt = 1'b0;
            check_out($sformatf("R2 vector %0d", i), 1'b1,
                      VECS[i].e_type, VECS[i].e_hi, VECS[i].e_lo);
        end

        // R3: hold with strobe low while every input moves
        drive(VECS[2], 1'b1);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            drive(VECS[k], 1'b0);
            @(negedge clk);
            check_out("R3 hold", 1'b1, 2'd2, 22'h295234, 16'h5678);
        end

        // R9 directed: two counters differing only above bit 25 give same stamp
        drive('{1'b0, 2'd0, 1'b0, 64'h0000_0000_0000_1400, 32'h0, 30'h0,
                32'h0, 30'h0, 2'd0, 22'h0, 16'h0}, 1'b1);
        @(negedge clk);
        check("R9 base tick", 64'(stamp_lo), 64'h0005);
        frc_ns = 64'h8000_0000_FC00_1400;
        @(negedge clk);
        evt = 1'b0;
        check("R9 high bits ignored", 64'(stamp_lo), 64'h0005);
        check("R9 high part zero", 64'(stamp_hi), 64'h0);

        // R1: mid-run reset clears the held stamp
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 mid-run reset", 1'b0, 2'd0, 22'h0, 16'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule